// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte standard configuration header of a single PCI function. It answers a plain register-access port: the requester presents an offset, an access width of 1, 2 or 4 bytes, write data and a read or write strobe. One cycle later the block returns a response with read data and an error flag. Identification, class, status, header type, subsystem and interrupt-pin fields are fixed by parameters. The command word, cache line size, latency timer, interrupt line, six base address registers and the expansion ROM register can be written, each only at the widths and offsets that suit it.

Each base address register keeps its space-type bits from the reset value. It supports the probe handshake: all ones are written, then read back, to learn the window size. Once software programs a nonzero base, the block exports the decoded window for that register: the start address with the I/O or memory space offset added, its size and an enable. It also raises a one-cycle change pulse so that downstream address decoding can reload.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, reads return the parameter values: {device, vendor} at offset 0x00, {class code, revision} at 0x08, {status, command=0} at 0x04, {max latency, min grant, interrupt pin, interrupt line} at 0x3C. All window enables are low.
- R2: A strobe produces `rsp_valid` for exactly one cycle, in the cycle after the strobe. Read data is little-endian and right-justified: lane k holds header byte offset+k, and lanes beyond the access width read as zero. `rsp_err` is only ever high together with `rsp_valid`.
- R3: An access width other than 1, 2 or 4 gives an error response, and so does a strobe with read and write both high. No state changes in either case.
- R4: Any offset of 0x40 or above gives an error response and changes no state.
- R5: Byte writes at 0x3C (interrupt line), 0x0C (cache line size) and 0x0D (latency timer) update only that byte, from `acc_wdata[7:0]`.
- R6: Byte writes at 0x08 to 0x0B and 0x3D to 0x3F are ignored without error. A byte write at any other header offset gives an error response.
- R7: A 2-byte write at 0x04 loads the command word only, leaving status unchanged. A 2-byte write at 0x0C loads only the cache line size from the low byte. A 2-byte write at 0x06 is ignored without error. Other 2-byte write offsets give an error.
- R8: A 4-byte write at 0x04 loads the command word from `acc_wdata[15:0]` and leaves status unchanged. 4-byte writes at offsets other than the command word, the base address registers (0x10 to 0x24) and the ROM register (0x30) are ignored without error.
- R9: A 4-byte write of 0xFFFFFFFF to a base address register loads ~(size-1) into its address bits and keeps its type bits: 2 bits for I/O (bit 0 set), 4 bits for memory. The window outputs and `range_chg` are unaffected.
- R10: Any other 4-byte base address register write stores the data with the type bits replaced by the held ones. If the resulting address bits are nonzero, the window base becomes that address plus the I/O or memory space offset, its enable rises, and `range_chg` pulses in the response cycle. If the address bits are zero, the window stays as it was and there is no pulse.
- R11: A 4-byte write of 0xFFFFFFFE to the ROM register makes it read back 0xFFFFFFFF. Any other 4-byte write value is stored as written.
- R12: `win_size` carries each register's size parameter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Read strobe, one cycle per access |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_addr | input | 8 | Byte offset within configuration space |
| acc_size | input | 3 | Access width in bytes (1, 2 or 4 legal) |
| acc_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response valid, one cycle after a strobe |
| rsp_err | output | 1 | Response reports a rejected access |
| rsp_rdata | output | 32 | Read data of the response |
| range_chg | output | 1 | One-cycle pulse when any window was reprogrammed |
| win_en | output | NUM_BARS | Per-register window enable |
| win_base | output | NUM_BARS*WIN_W | Per-register decoded window start |
| win_size | output | NUM_BARS*32 | Per-register window size |

## Verification
The checks assume the requester never issues a new strobe in the cycle its response is presented. They also assume reset is held for at least one edge before the first access. The bench keeps to this: every access is one strobe cycle, followed by a sampling cycle with both strobes low. Window stability is checked across every cycle without a write. Error responses are tied to the strobe cycle's offset and width, so the bench places illegal widths and high offsets among ordinary traffic rather than only at the start.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int NUM_BARS  = 6;
    localparam int HDR_BYTES = 64;

    localparam logic [7:0] OFF_COMMAND = 8'h04;
    localparam logic [7:0] OFF_STATUS  = 8'h06;
    localparam logic [7:0] OFF_CLS     = 8'h0C;
    localparam logic [7:0] OFF_LAT     = 8'h0D;
    localparam logic [7:0] OFF_BAR0    = 8'h10;
    localparam logic [7:0] OFF_ROM     = 8'h30;
    localparam logic [7:0] OFF_INTLINE = 8'h3C;

    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD,
        SZ_BAD
    } acc_sz_e;

    typedef struct packed {
        logic                cmd;
        logic                cls;
        logic                lat;
        logic                intl;
        logic                rom;
        logic [NUM_BARS-1:0] bar;
    } wr_act_t;

    function automatic acc_sz_e size_decode(input logic [2:0] sz);
        case (sz)
            3'd1:    return SZ_BYTE;
            3'd2:    return SZ_HALF;
            3'd4:    return SZ_WORD;
            default: return SZ_BAD;
        endcase
    endfunction

    function automatic logic [31:0] type_mask(input logic is_io);
        return is_io ? 32'h0000_0003 : 32'h0000_000F;
    endfunction

endpackage

// File: rtl/cfg_access_dec.sv
module cfg_access_dec
    import cfg_hdr_pkg::*;
(
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] addr,
    input  logic [2:0] size,
    output acc_sz_e    sz,
    output wr_act_t    act,
    output logic       err
);
    logic bad;
    logic reject;

    always_comb begin
        sz     = size_decode(size);
        bad    = (sz == SZ_BAD) || (addr >= 8'(HDR_BYTES)) || (rd && wr);
        reject = 1'b0;
        act    = '0;
        if (wr && !bad) begin
            case (sz)
                SZ_BYTE: begin
                    case (addr)
                        OFF_INTLINE: act.intl = 1'b1;
                        OFF_CLS:     act.cls  = 1'b1;
                        OFF_LAT:     act.lat  = 1'b1;
                        8'h08, 8'h09, 8'h0A, 8'h0B,
                        8'h3D, 8'h3E, 8'h3F: ;
                        default:     reject = 1'b1;
                    endcase
                end
                SZ_HALF: begin
                    case (addr)
                        OFF_COMMAND: act.cmd = 1'b1;
                        OFF_CLS:     act.cls = 1'b1;
                        OFF_STATUS:  ;
                        default:     reject = 1'b1;
                    endcase
                end
                SZ_WORD: begin
                    if (addr == OFF_COMMAND) act.cmd = 1'b1;
                    if (addr == OFF_ROM)     act.rom = 1'b1;
                    for (int i = 0; i < NUM_BARS; i++) begin
                        if (addr == OFF_BAR0 + 8'(4 * i)) act.bar[i] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        err = (rd || wr) && (bad || reject);
    end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] INIT_VAL = 32'h0,
    parameter logic [31:0] WIN_SIZE = 32'h0,
    parameter int          WIN_W    = 40,
    parameter logic [WIN_W-1:0] IO_BASE  = '0,
    parameter logic [WIN_W-1:0] MEM_BASE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    output logic [31:0]      bar_q,
    output logic             win_en,
    output logic [WIN_W-1:0] win_base,
    output logic             chg
);
    localparam logic             IS_IO = INIT_VAL[0];
    localparam logic [31:0]      TMASK = type_mask(IS_IO);
    localparam logic [WIN_W-1:0] SPACE = IS_IO ? IO_BASE : MEM_BASE;
    localparam logic [31:0]      PROBE = ~(WIN_SIZE - 32'd1) & ~TMASK;

    logic [31:0] addr_bits;
    logic        probe;

    always_comb begin
        addr_bits = wdata & ~TMASK;
        probe     = (wdata == 32'hFFFF_FFFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bar_q    <= INIT_VAL;
            win_en   <= 1'b0;
            win_base <= '0;
            chg      <= 1'b0;
        end else begin
            chg <= 1'b0;
            if (wr_en) begin
                if (probe) begin
                    bar_q <= PROBE | (bar_q & TMASK);
                end else begin
                    bar_q <= addr_bits | (bar_q & TMASK);
                    if (addr_bits != 32'h0) begin
                        win_base <= WIN_W'(addr_bits) + SPACE;
                        win_en   <= 1'b1;
                        chg      <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
    parameter logic [7:0]  REV_ID     = 8'h03,
    parameter logic [23:0] CLASS_CODE = 24'h020000,
    parameter logic [15:0] STATUS_VAL = 16'h0290,
    parameter logic [7:0]  HDR_TYPE   = 8'h00,
    parameter logic [15:0] SUB_VENDOR = 16'h0000,
    parameter logic [15:0] SUB_ID     = 16'h0000,
    parameter logic [7:0]  INT_LINE   = 8'h0A,
    parameter logic [7:0]  INT_PIN    = 8'h01,
    parameter logic [7:0]  MIN_GNT    = 8'h04,
    parameter logic [7:0]  MAX_LAT    = 8'h08,
    parameter logic [31:0] ROM_INIT   = 32'h0,
    parameter logic [NUM_BARS*32-1:0] BAR_INIT =
        {32'h0, 32'h0, 32'h0, 32'h0000_0008, 32'h0000_0001, 32'h0000_0000},
    parameter logic [NUM_BARS*32-1:0] BAR_SIZE =
        {32'h0, 32'h0, 32'h0, 32'h0010_0000, 32'h0000_0100, 32'h0000_1000},
    parameter int          WIN_W      = 40,
    parameter logic [WIN_W-1:0] IO_BASE  = 40'h00_8000_0000,
    parameter logic [WIN_W-1:0] MEM_BASE = 40'h10_0000_0000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_rd,
    input  logic                      acc_wr,
    input  logic [7:0]                acc_addr,
    input  logic [2:0]                acc_size,
    input  logic [31:0]               acc_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [31:0]               rsp_rdata,
    output logic                      range_chg,
    output logic [NUM_BARS-1:0]       win_en,
    output logic [NUM_BARS*WIN_W-1:0] win_base,
    output logic [NUM_BARS*32-1:0]    win_size
);
    acc_sz_e     sz;
    wr_act_t     act;
    logic        dec_err;
    logic [15:0] cmd_q;
    logic [7:0]  cls_q, lat_q, intl_q;
    logic [31:0] rom_q;
    logic [31:0] bar_q [NUM_BARS];
    logic [NUM_BARS-1:0] chg_vec;
    logic [7:0]  hdr [HDR_BYTES];
    logic [31:0] rdata_c;

    cfg_access_dec u_dec (
        .rd   (acc_rd),
        .wr   (acc_wr),
        .addr (acc_addr),
        .size (acc_size),
        .sz   (sz),
        .act  (act),
        .err  (dec_err)
    );

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        cfg_bar_slot #(
            .INIT_VAL (BAR_INIT[i*32 +: 32]),
            .WIN_SIZE (BAR_SIZE[i*32 +: 32]),
            .WIN_W    (WIN_W),
            .IO_BASE  (IO_BASE),
            .MEM_BASE (MEM_BASE)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (act.bar[i]),
            .wdata    (acc_wdata),
            .bar_q    (bar_q[i]),
            .win_en   (win_en[i]),
            .win_base (win_base[i*WIN_W +: WIN_W]),
            .chg      (chg_vec[i])
        );
    end

    assign win_size  = BAR_SIZE;
    assign range_chg = |chg_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= 16'h0;
            cls_q  <= 8'h0;
            lat_q  <= 8'h0;
            intl_q <= INT_LINE;
            rom_q  <= ROM_INIT;
        end else begin
            if (act.cmd)  cmd_q  <= acc_wdata[15:0];
            if (act.cls)  cls_q  <= acc_wdata[7:0];
            if (act.lat)  lat_q  <= acc_wdata[7:0];
            if (act.intl) intl_q <= acc_wdata[7:0];
            if (act.rom)  rom_q  <= (acc_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : acc_wdata;
        end
    end

    always_comb begin
        for (int b = 0; b < HDR_BYTES; b++) hdr[b] = 8'h0;
        {hdr[1], hdr[0]}   = VENDOR_ID;
        {hdr[3], hdr[2]}   = DEVICE_ID;
        {hdr[5], hdr[4]}   = cmd_q;
        {hdr[7], hdr[6]}   = STATUS_VAL;
        hdr[8]             = REV_ID;
        {hdr[11], hdr[10], hdr[9]} = CLASS_CODE;
        hdr[12]            = cls_q;
        hdr[13]            = lat_q;
        hdr[14]            = HDR_TYPE;
        for (int i = 0; i < NUM_BARS; i++) begin
            for (int k = 0; k < 4; k++) hdr[16 + 4*i + k] = bar_q[i][8*k +: 8];
        end
        {hdr[45], hdr[44]} = SUB_VENDOR;
        {hdr[47], hdr[46]} = SUB_ID;
        {hdr[51], hdr[50], hdr[49], hdr[48]} = rom_q;
        hdr[60]            = intl_q;
        hdr[61]            = INT_PIN;
        hdr[62]            = MIN_GNT;
        hdr[63]            = MAX_LAT;
    end

    always_comb begin
        logic [6:0] idx;
        logic       lane_on;
        rdata_c = 32'h0;
        for (int k = 0; k < 4; k++) begin
            idx     = {1'b0, acc_addr[5:0]} + 7'(k);
            lane_on = (k == 0) || (k == 1 && sz != SZ_BYTE) || (k >= 2 && sz == SZ_WORD);
            if (lane_on && idx < 7'(HDR_BYTES)) rdata_c[8*k +: 8] = hdr[idx[5:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= 32'h0;
        end else begin
            rsp_valid <= acc_rd || acc_wr;
            rsp_err   <= dec_err;
            rsp_rdata <= (acc_rd && !dec_err) ? rdata_c : 32'h0;
        end
    end
endmodule

// File: rtl/cfg_header_chk.sv
module cfg_header_chk #(
    parameter int NB = 6,
    parameter int WW = 40
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_rd,
    input logic             acc_wr,
    input logic [7:0]       acc_addr,
    input logic [2:0]       acc_size,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic             range_chg,
    input logic [NB-1:0]    win_en,
    input logic [NB*WW-1:0] win_base
);
    AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        (acc_rd || acc_wr) |=> rsp_valid);                                  // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(acc_rd || acc_wr) |=> !rsp_valid);                                // R2
    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);                                             // R2
    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (rst)
        ((acc_rd || acc_wr) && !(acc_size inside {3'd1, 3'd2, 3'd4})) |=> rsp_err); // R3
    AST_HIGH_OFFSET_ERR: assert property (@(posedge clk) disable iff (rst)
        ((acc_rd || acc_wr) && acc_addr >= 8'h40) |=> rsp_err);             // R4
    AST_CHG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        range_chg |-> $past(acc_wr));                                       // R10
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !acc_wr |=> ($stable(win_en) && $stable(win_base)));                // R10
endmodule

bind cfg_header_regs cfg_header_chk #(.NB(cfg_hdr_pkg::NUM_BARS), .WW(WIN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .range_chg (range_chg),
    .win_en    (win_en),
    .win_base  (win_base)
);

// File: tb/sim_cfg_header_regs.sv
module sim_cfg_header_regs;
    localparam int NB = 6;
    localparam int WW = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_rd = 1'b0, acc_wr = 1'b0;
    logic [7:0] acc_addr = '0;
    logic [2:0] acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic rsp_valid, rsp_err, range_chg;
    logic [31:0] rsp_rdata;
    logic [NB-1:0] win_en;
    logic [NB*WW-1:0] win_base;
    logic [NB*32-1:0] win_size;

    int checks = 0, errors = 0, cyc = 0;
    logic g_valid, g_err, g_chg;
    logic [31:0] g_data;

    always #2.5 clk = ~clk;

    cfg_header_regs u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic rd, input logic wr, input logic [7:0] a,
                       input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_rd = rd; acc_wr = wr; acc_addr = a; acc_size = s; acc_wdata = d;
        @(negedge clk);
        g_valid = rsp_valid; g_err = rsp_err; g_data = rsp_rdata; g_chg = range_chg;
        acc_rd = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [2:0] s,
                          input logic [31:0] exp);
        acc(1'b1, 1'b0, a, s, 32'h0);
        chk({tag, " valid"}, 64'(g_valid), 64'(1'b1));
        chk({tag, " data"}, 64'(g_data), 64'(exp));
    endtask

    task automatic wr_chk(input string tag, input logic [7:0] a, input logic [2:0] s,
                          input logic [31:0] d, input logic exp_err);
        acc(1'b0, 1'b1, a, s, d);
        chk({tag, " err"}, 64'(g_err), 64'(exp_err));
    endtask

    task automatic t_reset;
        rd_chk("R1 id", 8'h00, 3'd4, 32'h3C4D_1A2B);
        rd_chk("R1 class", 8'h08, 3'd4, 32'h0200_0003);
        rd_chk("R1 cmdstat", 8'h04, 3'd4, 32'h0290_0000);
        rd_chk("R1 intr", 8'h3C, 3'd4, 32'h0804_010A);
        chk("R1 win_en", 64'(win_en), 64'h0);
        rd_chk("R2 byte lane", 8'h01, 3'd1, 32'h0000_001A);
        rd_chk("R2 half lane", 8'h02, 3'd2, 32'h0000_3C4D);
        acc(1'b0, 1'b0, 8'h00, 3'd4, 32'h0);
        chk("R2 idle no rsp", 64'(g_valid), 64'h0);
    endtask

    task automatic t_illegal;
        acc(1'b1, 1'b0, 8'h00, 3'd3, 32'h0);
        chk("R3 size3 err", 64'(g_err), 64'h1);
        wr_chk("R3 size0", 8'h3C, 3'd0, 32'h55, 1'b1);
        acc(1'b1, 1'b1, 8'h3C, 3'd1, 32'h66);
        chk("R3 both strobes err", 64'(g_err), 64'h1);
        acc(1'b1, 1'b0, 8'h40, 3'd4, 32'h0);
        chk("R4 high read err", 64'(g_err), 64'h1);
        wr_chk("R4 high write", 8'h7C, 3'd1, 32'h77, 1'b1);
        rd_chk("R3 R4 no change", 8'h3C, 3'd4, 32'h0804_010A);
    endtask

    task automatic t_bytes;
        wr_chk("R5 lat", 8'h0D, 3'd1, 32'h0000_335A, 1'b0);
        rd_chk("R5 lat only", 8'h0C, 3'd4, 32'h0000_5A00);
        wr_chk("R5 cls", 8'h0C, 3'd1, 32'h0000_0010, 1'b0);
        rd_chk("R5 cls only", 8'h0C, 3'd4, 32'h0000_5A10);
        wr_chk("R5 intl", 8'h3C, 3'd1, 32'h0000_0033, 1'b0);
        wr_chk("R6 pin ignored", 8'h3D, 3'd1, 32'h0000_00FF, 1'b0);
        wr_chk("R6 rev ignored", 8'h08, 3'd1, 32'h0000_00FF, 1'b0);
        rd_chk("R6 intr after", 8'h3C, 3'd4, 32'h0804_0133);
        rd_chk("R6 class after", 8'h08, 3'd4, 32'h0200_0003);
        wr_chk("R6 id byte", 8'h00, 3'd1, 32'h0000_0011, 1'b1);
        wr_chk("R6 cmd byte", 8'h04, 3'd1, 32'h0000_0011, 1'b1);
    endtask

    task automatic t_halves;
        wr_chk("R7 cmd16", 8'h04, 3'd2, 32'h0000_0107, 1'b0);
        rd_chk("R7 cmd16 read", 8'h04, 3'd4, 32'h0290_0107);
        wr_chk("R7 cls16", 8'h0C, 3'd2, 32'h0000_AB77, 1'b0);
        rd_chk("R7 cls16 read", 8'h0C, 3'd4, 32'h0000_5A77);
        wr_chk("R7 status16", 8'h06, 3'd2, 32'h0000_FFFF, 1'b0);
        rd_chk("R7 status kept", 8'h04, 3'd4, 32'h0290_0107);
        wr_chk("R7 id16", 8'h00, 3'd2, 32'h0000_FFFF, 1'b1);
        wr_chk("R8 cmd32", 8'h04, 3'd4, 32'hFFFF_0006, 1'b0);
        rd_chk("R8 cmd32 read", 8'h04, 3'd4, 32'h0290_0006);
        wr_chk("R8 id32 ignored", 8'h00, 3'd4, 32'h1234_5678, 1'b0);
        rd_chk("R8 id kept", 8'h00, 3'd4, 32'h3C4D_1A2B);
    endtask

    task automatic t_bars;
        wr_chk("R9 bar0 probe", 8'h10, 3'd4, 32'hFFFF_FFFF, 1'b0);
        chk("R9 no pulse", 64'(g_chg), 64'h0);
        rd_chk("R9 bar0 size", 8'h10, 3'd4, 32'hFFFF_F000);
        wr_chk("R9 bar1 probe", 8'h14, 3'd4, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R9 bar1 io size", 8'h14, 3'd4, 32'hFFFF_FF01);
        wr_chk("R9 bar2 probe", 8'h18, 3'd4, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R9 bar2 type kept", 8'h18, 3'd4, 32'hFFF0_0008);
        chk("R9 win_en idle", 64'(win_en), 64'h0);

        wr_chk("R10 bar0 prog", 8'h10, 3'd4, 32'h1234_5678, 1'b0);
        chk("R10 bar0 pulse", 64'(g_chg), 64'h1);
        chk("R10 bar0 base", 64'(win_base[0 +: WW]), 64'h10_1234_5670);
        rd_chk("R10 bar0 read", 8'h10, 3'd4, 32'h1234_5670);
        wr_chk("R10 bar1 prog", 8'h14, 3'd4, 32'h0000_ABCF, 1'b0);
        chk("R10 bar1 pulse", 64'(g_chg), 64'h1);
        chk("R10 bar1 base", 64'(win_base[WW +: WW]), 64'h00_8000_ABCC);
        rd_chk("R10 bar1 read", 8'h14, 3'd4, 32'h0000_ABCD);
        wr_chk("R10 bar3 zero", 8'h1C, 3'd4, 32'h0000_0007, 1'b0);
        chk("R10 bar3 no pulse", 64'(g_chg), 64'h0);
        wr_chk("R10 bar0 clear", 8'h10, 3'd4, 32'h0000_0000, 1'b0);
        chk("R10 clear no pulse", 64'(g_chg), 64'h0);
        chk("R10 win_en", 64'(win_en), 64'h3);
        chk("R10 bar0 base kept", 64'(win_base[0 +: WW]), 64'h10_1234_5670);
        chk("R12 size0", 64'(win_size[0 +: 32]), 64'h1000);
        chk("R12 size2", 64'(win_size[64 +: 32]), 64'h10_0000);
    endtask

    task automatic t_rom;
        wr_chk("R11 rom probe", 8'h30, 3'd4, 32'hFFFF_FFFE, 1'b0);
        rd_chk("R11 rom all ones", 8'h30, 3'd4, 32'hFFFF_FFFF);
        wr_chk("R11 rom store", 8'h30, 3'd4, 32'h00C0_0001, 1'b0);
        rd_chk("R11 rom read", 8'h30, 3'd4, 32'h00C0_0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_illegal();
        t_bytes();
        t_halves();
        t_bars();
        t_rom();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule